// File: doc/BRIEF.md
# USB Bus Event Interrupt Status Register

This block keeps the bus-level event flags of a small USB device controller and turns them into one interrupt request. It samples a decoded line-state input and a one-cycle strobe that marks a received start-of-frame token. From these it finds four events:

- a start-of-frame;
- a suspend, which is a long idle J state on the bus;
- the end of a bus reset, which is a long SE0 followed by any other line state;
- wake-up activity, which is the bus leaving idle while the controller is suspended.

Each event is latched into a sticky bit of an 8-bit status word.

Software reads the status word through a read port. It clears flags through a write strobe: writing 0 to a flag bit clears that flag, and writing 1 leaves it unchanged. An enable vector with the same bit layout comes from outside the block and masks the flags into the interrupt request.

A two-state bus machine tracks whether the controller is suspended:

- **BUS_ACTIVE** moves to **BUS_SUSPENDED** on the transition *idle_timeout*.
- **BUS_SUSPENDED** moves back to **BUS_ACTIVE** on the transition *sw_resume*, when software clears the suspend flag.
- **BUS_SUSPENDED** also moves back to **BUS_ACTIVE** on the transition *reset_end*, when a bus reset finishes.

While in BUS_SUSPENDED, any line state other than J raises the wake-up flag.

Top module: `usb_busevt_irq`

## Requirements
- R1: After reset the status word reads 0x00, `bus_suspended` is 0 and `irq` is 0.
- R2: Bits 7, 6, 2 and 1 of the status word always read 0, and writes to them have no effect.
- R3: A clock edge that samples `sof_seen` high sets bit 3 (start-of-frame).
- R4: Bit 0 (suspend) is set at the edge that samples the J state (`line_state` = 2'b01) for the IDLE_MS*CYC_PER_MS-th consecutive time. It is not set one sample earlier, and it is set only once per idle period. The same edge moves the machine from BUS_ACTIVE to BUS_SUSPENDED.
- R5: Bit 5 (wake-up) is set at an edge where the machine is in BUS_SUSPENDED and the line is not J. A line state other than J in BUS_ACTIVE does not set it.
- R6: Bit 4 (end-of-reset) is set at the first edge that samples a line state other than SE0 (SE0 = 2'b00) after at least RST_MIN_CYC consecutive SE0 samples. A shorter SE0 does not set it. The same edge returns the machine to BUS_ACTIVE.
- R7: A write (`wr_en` high) with a 0 in a flag's bit position clears that flag. A 1 in that position leaves the flag unchanged. With no write, a set flag stays set.
- R8: When hardware sets a flag in the same cycle that software clears it, the flag ends up set.
- R9: `irq` is 1 exactly when some flag is 1 and the `irq_en` bit at the same position is 1.
- R10: A write that clears bit 0 while the machine is in BUS_SUSPENDED returns it to BUS_ACTIVE on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_state | input | 2 | Decoded line state: 00 SE0, 01 J, 10 K, 11 SE1 (treated as neither idle nor SE0) |
| sof_seen | input | 1 | One-cycle strobe when a start-of-frame token is detected |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 8 | Write data; a 0 in a flag position clears that flag |
| irq_en | input | 8 | Per-flag interrupt enables, with the same bit positions as the status word |
| rd_data | output | 8 | Current status word |
| bus_suspended | output | 1 | High while the machine is in BUS_SUSPENDED |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches several properties on every cycle:

- the reserved bits are zero;
- the interrupt request matches the enabled flags;
- a SOF strobe always leaves bit 3 set;
- flags fall only after a write of 0 to their position;
- the wake-up flag rises only after a suspended cycle;
- entering BUS_SUSPENDED always comes with the suspend flag;
- a suspend-clearing write always leaves BUS_SUSPENDED;
- a new end-of-reset flag is never seen while suspended.

The exact cycle counts can only be shown by the bench's scenarios. These include a suspend arriving on the last idle sample and not one sample earlier, a reset one SE0 sample short of the limit, the single suspend per idle period, and a wake-up that is refused while active.

// File: rtl/usbev_pkg.sv
package usbev_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic {
        BUS_ACTIVE    = 1'b0,
        BUS_SUSPENDED = 1'b1
    } bus_st_t;

    localparam int STAT_W   = 8;
    localparam int BIT_SUSP = 0;
    localparam int BIT_SOF  = 3;
    localparam int BIT_EOR  = 4;
    localparam int BIT_WAKE = 5;
    localparam logic [STAT_W-1:0] FLAG_MASK = 8'b0011_1001;

endpackage

// File: rtl/usbev_idle_timer.sv
module usbev_idle_timer #(
    parameter int IDLE_CYC = 144000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_is_j,
    output logic idle_hit
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] LIM    = CW'(IDLE_CYC);
    localparam logic [CW-1:0] LIM_M1 = CW'(IDLE_CYC - 1);

    logic [CW-1:0] cnt;

    // Saturating count of consecutive J samples; saturation gives one hit per idle period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!line_is_j) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign idle_hit = line_is_j && (cnt == LIM_M1);
endmodule

// File: rtl/usbev_reset_det.sv
module usbev_reset_det #(
    parameter int RST_MIN_CYC = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_is_se0,
    output logic eor_hit
);
    localparam int CW = $clog2(RST_MIN_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(RST_MIN_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!line_is_se0) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    // First non-SE0 sample after a long enough SE0 run
    assign eor_hit = !line_is_se0 && (cnt == LIM);
endmodule

// File: rtl/usbev_bus_fsm.sv
module usbev_bus_fsm
    import usbev_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_hit,
    input  logic eor_hit,
    input  logic line_is_j,
    input  logic susp_clr,
    output logic suspended,
    output logic wake_hit
);
    bus_st_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            BUS_ACTIVE: begin
                if (idle_hit && !eor_hit) state_nx = BUS_SUSPENDED;    // idle_timeout
            end
            BUS_SUSPENDED: begin
                if (eor_hit || susp_clr) state_nx = BUS_ACTIVE;        // reset_end / sw_resume
            end
            default: state_nx = BUS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BUS_ACTIVE;
        else        state <= state_nx;
    end

    always_comb begin
        suspended = 1'b0;
        wake_hit  = 1'b0;
        unique case (state)
            BUS_ACTIVE: ;
            BUS_SUSPENDED: begin
                suspended = 1'b1;
                wake_hit  = !line_is_j;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/usbev_status_reg.sv
module usbev_status_reg
    import usbev_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] flags
);
    logic unused_rsvd;
    assign unused_rsvd = ^(set_vec & ~FLAG_MASK) ^ ^(wr_data & ~FLAG_MASK);

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (FLAG_MASK[i]) begin : g_live
            // A hardware set wins over a software clear in the same cycle
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flags[i] <= 1'b0;
                else        flags[i] <= set_vec[i] | (flags[i] & ~(wr_en & ~wr_data[i]));
            end
        end else begin : g_rsvd
            assign flags[i] = 1'b0;
        end
    end
endmodule

// File: rtl/usb_busevt_irq.sv
module usb_busevt_irq
    import usbev_pkg::*;
#(
    parameter int CYC_PER_MS  = 48000,
    parameter int IDLE_MS     = 3,
    parameter int RST_MIN_CYC = 120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_state,
    input  logic       sof_seen,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [7:0] irq_en,
    output logic [7:0] rd_data,
    output logic       bus_suspended,
    output logic       irq
);
    localparam int IDLE_CYC = IDLE_MS * CYC_PER_MS;

    logic line_is_j, line_is_se0;
    logic idle_hit, eor_hit, wake_hit, susp_clr;
    logic [STAT_W-1:0] set_vec, flags;

    assign line_is_j   = (line_state == LS_J);
    assign line_is_se0 = (line_state == LS_SE0);
    assign susp_clr    = wr_en && !wr_data[BIT_SUSP];

    usbev_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
        .clk(clk), .rst_n(rst_n), .line_is_j(line_is_j), .idle_hit(idle_hit)
    );

    usbev_reset_det #(.RST_MIN_CYC(RST_MIN_CYC)) u_rst (
        .clk(clk), .rst_n(rst_n), .line_is_se0(line_is_se0), .eor_hit(eor_hit)
    );

    usbev_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .idle_hit(idle_hit), .eor_hit(eor_hit),
        .line_is_j(line_is_j), .susp_clr(susp_clr),
        .suspended(bus_suspended), .wake_hit(wake_hit)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[BIT_SUSP] = idle_hit;
        set_vec[BIT_SOF]  = sof_seen;
        set_vec[BIT_EOR]  = eor_hit;
        set_vec[BIT_WAKE] = wake_hit;
    end

    usbev_status_reg u_stat (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .wr_en(wr_en), .wr_data(wr_data), .flags(flags)
    );

    assign rd_data = flags;
    assign irq     = |(flags & irq_en);
endmodule

// File: rtl/usb_busevt_irq_chk.sv
module usb_busevt_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sof_seen,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] irq_en,
    input logic [7:0] rd_data,
    input logic       bus_suspended,
    input logic       irq
);
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7:6] == 2'b00) && (rd_data[2:1] == 2'b00));

    assert_sof_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sof_seen |=> rd_data[3]);

    assert_susp_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_suspended) |-> rd_data[0]);

    assert_wake_only_susp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[5]) |-> $past(bus_suspended));

    assert_eor_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[4]) |-> !bus_suspended);

    assert_sticky_sof_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[3]) |-> $past(wr_en && !wr_data[3]));

    assert_sticky_eor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[4]) |-> $past(wr_en && !wr_data[4]));

    assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(rd_data & irq_en));

    assert_clr_resume_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_suspended && wr_en && !wr_data[0]) |=> !bus_suspended);
endmodule

bind usb_busevt_irq usb_busevt_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sof_seen(sof_seen), .wr_en(wr_en),
    .wr_data(wr_data), .irq_en(irq_en), .rd_data(rd_data),
    .bus_suspended(bus_suspended), .irq(irq)
);

// File: tb/usb_busevt_irq_bench.sv
module usb_busevt_irq_bench;
    localparam int CPM   = 4;
    localparam int IDLE  = 3 * CPM;
    localparam int RMIN  = 5;
    localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line_state = K;
    logic       sof_seen = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'hFF;
    logic [7:0] irq_en = 8'h00;
    logic [7:0] rd_data;
    logic       bus_suspended, irq;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    usb_busevt_irq #(.CYC_PER_MS(CPM), .IDLE_MS(3), .RST_MIN_CYC(RMIN)) u_usb_busevt_irq (
        .clk(clk), .rst_n(rst_n), .line_state(line_state), .sof_seen(sof_seen),
        .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
        .rd_data(rd_data), .bus_suspended(bus_suspended), .irq(irq)
    );

    // vector: {line[1:0], sof, wr_en, wr_data[7:0], irq_en[7:0], exp_rd[7:0], exp_irq}
    localparam int NV = 9;
    localparam logic [28:0] VEC [NV] = '{
        {K, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h08, 1'b0},  // R3 SOF sets bit 3
        {K, 1'b0, 1'b0, 8'hFF, 8'h08, 8'h08, 1'b1},  // R9 enabled flag raises irq
        {K, 1'b0, 1'b1, 8'hFF, 8'h08, 8'h08, 1'b1},  // R7 writing ones keeps flag
        {K, 1'b0, 1'b1, 8'hF7, 8'h08, 8'h00, 1'b0},  // R7 writing zero clears flag
        {K, 1'b1, 1'b1, 8'hF7, 8'h00, 8'h08, 1'b0},  // R8 set beats clear
        {K, 1'b0, 1'b1, 8'h00, 8'hFF, 8'h00, 1'b0},  // R7 clear all
        {K, 1'b1, 1'b0, 8'hFF, 8'hF7, 8'h08, 1'b0},  // R9 masked flag gives no irq
        {K, 1'b0, 1'b1, 8'hF7, 8'h00, 8'h00, 1'b0},  // R7 clear
        {K, 1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b0}   // R2 reserved writes ignored
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] ls, input logic sof, input logic we, input logic [7:0] wd);
        @(negedge clk);
        line_state = ls; sof_seen = sof; wr_en = we; wr_data = wd;
        @(posedge clk);
        #1;
    endtask

    task automatic run(input logic [1:0] ls, input int n);
        for (int i = 0; i < n; i++) step(ls, 1'b0, 1'b0, 8'hFF);
    endtask

    initial begin
        #(20000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #23;
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 bus_suspended", {7'd0, bus_suspended}, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            line_state = VEC[v][28:27]; sof_seen = VEC[v][26]; wr_en = VEC[v][25];
            wr_data = VEC[v][24:17]; irq_en = VEC[v][16:9];
            @(posedge clk);
            #1;
            chk($sformatf("vector %0d rd_data", v), rd_data, VEC[v][8:1]);
            chk($sformatf("vector %0d irq", v), {7'd0, irq}, {7'd0, VEC[v][0]});
        end
        irq_en = 8'h00;

        // R4: suspend on the IDLE-th J sample, not one earlier
        run(K, 1);
        run(J, IDLE - 1);
        chk("R4 no suspend one sample early", rd_data, 8'h00);
        run(J, 1);
        chk("R4 suspend flag", rd_data, 8'h01);
        chk("R4 suspended state", {7'd0, bus_suspended}, 8'h01);
        run(J, 5);
        step(J, 1'b0, 1'b1, 8'hFE);
        chk("R10 clear suspend exits", {7'd0, bus_suspended}, 8'h00);
        run(J, 3 * IDLE);
        chk("R4 once per idle period", rd_data, 8'h00);
        chk("R4 stays active", {7'd0, bus_suspended}, 8'h00);

        // R5: non-J while active does not wake
        run(K, 2);
        chk("R5 no wake while active", rd_data, 8'h00);
        run(J, IDLE);
        chk("R4 second suspend", rd_data, 8'h01);
        run(K, 1);
        chk("R5 wake while suspended", rd_data, 8'h21);
        chk("R5 still suspended", {7'd0, bus_suspended}, 8'h01);
        step(K, 1'b0, 1'b1, 8'hFE);
        chk("R10 resume by clear", {7'd0, bus_suspended}, 8'h00);
        chk("R7 wake stays sticky", rd_data, 8'h20);
        step(K, 1'b0, 1'b1, 8'hDF);
        chk("R7 wake cleared", rd_data, 8'h00);

        // R6: reset length boundary
        run(SE0, RMIN - 1);
        run(K, 1);
        chk("R6 short SE0 no end-of-reset", rd_data, 8'h00);
        run(SE0, RMIN);
        chk("R6 not flagged during SE0", rd_data, 8'h00);
        run(K, 1);
        chk("R6 end-of-reset flag", rd_data, 8'h10);
        step(K, 1'b0, 1'b1, 8'hEF);

        // R6: end of reset leaves the suspended state
        run(J, IDLE);
        chk("R6 suspended before reset", {7'd0, bus_suspended}, 8'h01);
        run(SE0, RMIN);
        run(J, 1);
        chk("R6 reset exits suspend", {7'd0, bus_suspended}, 8'h00);
        chk("R6 flags after reset", rd_data & 8'h11, 8'h11);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule